// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block turns a platform reset into the reset seen by a processor and, around the moment that reset lets go, drives a bus-request strap line that the processor samples on the trailing edge of its reset. While the platform reset input is low, the processor reset output is held low. Once the input rises, a two-flop synchronizer brings the release into the clock domain. The processor reset then stays low for a programmable stretch of clock cycles, on the order of a millisecond in a real system, before it is released.

For the whole time the processor reset is low, the strap line is driven low. This meets the setup time the processor needs before the release. After the release, the strap keeps being driven low for a bounded hold window of 2 to 20 cycles. Its driver is then turned off, so the line floats to high impedance and other agents may use it.

If the platform reset goes low again at any moment, even during the stretch or the hold window, all state returns at once to the reset phase, and the full sequence runs again from its start after the next release.

Top module: `cpu_reset_strap_seq`

## Requirements
- R1: `cpu_rst_n` is 0 whenever `rst_in_n` is 0, and it goes to 0 without waiting for a clock edge when `rst_in_n` falls.
- R2: Counting rising clock edges at which `rst_in_n` is 1 since it last rose, `cpu_rst_n` stays 0 through edge STRETCH_CYC+2. It becomes 1 after edge STRETCH_CYC+3. Two of these edges belong to the synchronizer, one to the phase change, and STRETCH_CYC to the stretch.
- R3: Whenever `cpu_rst_n` is 0, `strap_oe` is 1 and `strap_o` is 0, meaning the strap is driven low.
- R4: The strap is driven low while `rst_in_n` is 1 and `cpu_rst_n` is 0 for at least 4 cycles before `cpu_rst_n` rises. A STRETCH_CYC below 4 is rejected at elaboration.
- R5: After `cpu_rst_n` rises, `strap_oe`=1 and `strap_o`=0 hold for exactly HOLD_CYC cycles. HOLD_CYC must lie in 2..20, or elaboration fails.
- R6: When the hold window ends, `strap_oe` becomes 0 and `strap_o` becomes 1. Both stay that way, with `cpu_rst_n`=1, until `rst_in_n` falls again.
- R7: A fall of `rst_in_n` during the stretch, the hold window or the released phase restarts the sequence. The timing of R2 and R5 then applies from the next rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_in_n | input | 1 | Platform reset, active low, asynchronous |
| cpu_rst_n | output | 1 | Processor reset, active low |
| strap_o | output | 1 | Strap level: 0 while driven, 1 once the driver is off |
| strap_oe | output | 1 | Strap output enable; 0 means high impedance |

## Verification
The bench builds two copies from the same stimulus. One uses the smallest legal values, STRETCH_CYC=4 and HOLD_CYC=2, so the setup margin and the shortest hold sit exactly at their limits. The other uses STRETCH_CYC=9 and HOLD_CYC=20, which reaches the longest permitted hold. Because the two copies are timed differently, one reset pulse lands in the stretch of one copy and in the hold window or released phase of the other. This exercises the restart of R7 in several phases, and one fall of the input arrives between clock edges to show that reset assertion does not wait for the clock.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    PH_RESET   = 2'd0,
    PH_STRETCH = 2'd1,
    PH_HOLD    = 2'd2,
    PH_FREE    = 2'd3
  } rsq_phase_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rel_o = sh_q[STAGES-1];

  generate
    if (STAGES < 2) begin : g_bad_stages
      $error("rsq_sync needs at least two stages");
    end
  endgenerate

  // R2: the last stage only rises after the stage before it was already high
  assert_sync_order_R2: assert property (@(posedge clk) disable iff (!arst_n)
    sh_q[STAGES-1] |-> $past(sh_q[STAGES-2]));
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2: without a load the count only moves down by one
  assert_timer_step_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cpu_reset_strap_seq.sv
module cpu_reset_strap_seq
  import rsq_pkg::*;
#(
  parameter int STRETCH_CYC = 100000,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic cpu_rst_n,
  output logic strap_o,
  output logic strap_oe
);
  localparam int MAXC = (STRETCH_CYC > HOLD_CYC) ? STRETCH_CYC : HOLD_CYC;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] STRETCH_LD = W'(STRETCH_CYC - 1);
  localparam logic [W-1:0] HOLD_LD    = W'(HOLD_CYC - 1);

  generate
    if (HOLD_CYC < 2 || HOLD_CYC > 20) begin : g_bad_hold
      $error("HOLD_CYC must lie in 2..20");
    end
    if (STRETCH_CYC < 4) begin : g_bad_stretch
      $error("STRETCH_CYC must be at least 4 for strap setup");
    end
  endgenerate

  logic         rel_sync;
  logic         tmr_zero;
  logic         tmr_load;
  logic [W-1:0] tmr_val;
  rsq_phase_e   phase_q;
  rsq_phase_e   phase_d;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_in_n),
    .rel_o  (rel_sync)
  );

  rsq_timer #(.W(W)) u_timer (
    .clk    (clk),
    .arst_n (rst_in_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      PH_RESET: if (rel_sync) begin
        phase_d  = PH_STRETCH;
        tmr_load = 1'b1;
        tmr_val  = STRETCH_LD;
      end
      PH_STRETCH: if (tmr_zero) begin
        phase_d  = PH_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_LD;
      end
      PH_HOLD: if (tmr_zero) begin
        phase_d = PH_FREE;
      end
      default: phase_d = PH_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) phase_q <= PH_RESET;
    else           phase_q <= phase_d;
  end

  assign cpu_rst_n = (phase_q == PH_HOLD) || (phase_q == PH_FREE);
  assign strap_oe  = (phase_q != PH_FREE);
  assign strap_o   = (phase_q == PH_FREE);

  // cycles spent in the hold window, kept only for the bound check
  logic [W-1:0] hold_run_q;
  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)                hold_run_q <= '0;
    else if (phase_q == PH_HOLD)  hold_run_q <= hold_run_q + 1'b1;
    else                          hold_run_q <= '0;
  end

  // R5: the strap is never held past HOLD_CYC cycles after release
  assert_hold_bound_R5: assert property (@(posedge clk) disable iff (!rst_in_n)
    (phase_q == PH_HOLD) |-> (int'(hold_run_q) < HOLD_CYC));

  // R3: strap driven low while processor reset is active
  assert_strap_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_in_n)
    !cpu_rst_n |-> (strap_oe && !strap_o));

  // R6: once released, the strap stays off until the next reset
  assert_free_sticky_R6: assert property (@(posedge clk) disable iff (!rst_in_n)
    (phase_q == PH_FREE) |=> (phase_q == PH_FREE));

  // R2: processor reset only rises after the synchronized release
  assert_rise_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_in_n)
    $rose(cpu_rst_n) |-> $past(rel_sync));
endmodule

// File: tb/cpu_reset_strap_seq_bench.sv
module cpu_reset_strap_seq_bench;
  localparam int PERIOD = 10;
  localparam int SA = 4, HA = 2, SB = 9, HB = 20;

  logic clk;
  logic rst_in_n;
  logic cpu_a, so_a, oe_a, cpu_b, so_b, oe_b;
  int   total, bad, k;
  int   setup_a, setup_b;
  logic prev_cpu_a, prev_cpu_b;
  bit   done;

  cpu_reset_strap_seq #(.STRETCH_CYC(SA), .HOLD_CYC(HA)) u_cpu_reset_strap_seq (
    .clk(clk), .rst_in_n(rst_in_n), .cpu_rst_n(cpu_a), .strap_o(so_a), .strap_oe(oe_a));
  cpu_reset_strap_seq #(.STRETCH_CYC(SB), .HOLD_CYC(HB)) u_cpu_reset_strap_seq_b (
    .clk(clk), .rst_in_n(rst_in_n), .cpu_rst_n(cpu_b), .strap_o(so_b), .strap_oe(oe_b));

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // reference: edges seen with the input released
  always @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) k <= 0;
    else if (k < 100000) k <= k + 1;
  end

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic string phase_tag(input int s, input int h);
    if (!rst_in_n)        return "R1";
    if (k < s + 3)        return "R2";
    if (k < s + 3 + h)    return "R5";
    return "R6";
  endfunction

  task automatic check_all();
    string ta, tb;
    ta = phase_tag(SA, HA);
    tb = phase_tag(SB, HB);
    chk(ta, "A cpu_rst_n", int'(cpu_a), int'(k >= SA + 3));
    chk(ta == "R2" ? "R3" : ta, "A strap_oe", int'(oe_a), int'(k < SA + 3 + HA));
    chk(ta == "R2" ? "R3" : ta, "A strap_o", int'(so_a), int'(k >= SA + 3 + HA));
    chk(tb, "B cpu_rst_n", int'(cpu_b), int'(k >= SB + 3));
    chk(tb == "R2" ? "R3" : tb, "B strap_oe", int'(oe_b), int'(k < SB + 3 + HB));
    chk(tb == "R2" ? "R3" : tb, "B strap_o", int'(so_b), int'(k >= SB + 3 + HB));
    // R4: setup count at the release edge
    if (cpu_a && !prev_cpu_a) chk("R4", "A setup cycles", int'(setup_a >= 4), 1);
    if (cpu_b && !prev_cpu_b) chk("R4", "B setup cycles", int'(setup_b >= 4), 1);
    if (!rst_in_n) begin setup_a = 0; setup_b = 0; end
    else begin
      if (!cpu_a && oe_a && !so_a) setup_a++;
      if (!cpu_b && oe_b && !so_b) setup_b++;
    end
    prev_cpu_a = cpu_a;
    prev_cpu_b = cpu_b;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    setup_a = 0; setup_b = 0; prev_cpu_a = 0; prev_cpu_b = 0;
    rst_in_n = 1'b0;
    run(5);                       // R1 reset state
    rst_in_n = 1'b1;
    run(45);                      // full sequence for both, R2 R5 R6
    rst_in_n = 1'b0;              // R7 from released phase
    run(3);
    rst_in_n = 1'b1;
    run(5);                       // k=5: A stretching
    rst_in_n = 1'b0;              // R7 during A stretch
    run(2);
    rst_in_n = 1'b1;
    run(20);                      // A free, B in hold
    rst_in_n = 1'b0;              // R7 during B hold
    run(2);
    rst_in_n = 1'b1;
    run(40);
    // R1 asynchronous assertion between edges
    @(negedge clk);
    #2 rst_in_n = 1'b0;
    #1;
    chk("R1", "A async cpu_rst_n", int'(cpu_a), 0);
    chk("R1", "B async cpu_rst_n", int'(cpu_b), 0);
    chk("R7", "A async strap_oe", int'(oe_a), 1);
    run(3);
    rst_in_n = 1'b1;
    run(40);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule